// File: doc/BRIEF.md
# Motion Centroid Engine

This block finds where motion is in a video frame and reports one object position per frame. It takes colour pixels in scan order, left to right and then top to bottom. Each pixel comes with the grey level that the same location had in the previous frame, read from external frame memory. The block turns the colour pixel into an 8-bit grey level and takes the absolute difference from the stored grey level. Where that difference is larger than a threshold, it counts the pixel as moving. For every moving pixel it adds the column and row to running sums and increments a count.

When the last pixel of the last line has been taken, the block divides each sum by the count. It then pulses a result strobe with the average column and the average row. A host processor reads them to predict where the object goes next. If nothing moved, the block reports a no-motion flag and keeps the previous position. If a new frame starts before the old one has all its lines, the block raises a frame error and reports no result for that frame.

The pixel input is a valid/ready stream. A beat transfers on a clock edge where both `s_valid` and `s_ready` are high. The block accepts one beat per clock for the whole of a frame. It drops `s_ready` only from the edge that takes the final beat until the result has been reported. A source must hold its beat stable while `s_ready` is low. The threshold and the result pins are plain signals with no handshake.

Top module: `motion_centroid`

## Requirements
- R1: The colour beat packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Its grey level is (77*red + 150*green + 29*blue) >> 8, which gives 8 bits.
- R2: A pixel is moving only when |grey − previous grey| is strictly greater than the active threshold. A difference equal to the threshold does not count.
- R3: The active threshold is copied from `thresh_i` on every clock while the block is idle. Changes to `thresh_i` during a frame have no effect on that frame.
- R4: The beat with `s_sof` high is column 0, row 0. Each later beat is one column further along, and a beat with `s_eol` high ends its row. The frame is complete on the `s_eol` beat of row ROWS−1.
- R5: After a complete frame with at least one moving pixel, `res_valid` pulses for one cycle. At that point `res_x` is floor(sum of moving columns / count) and `res_y` is floor(sum of moving rows / count).
- R6: After a complete frame with no moving pixel, `res_valid` pulses with `res_no_motion` high, and `res_x`/`res_y` keep their previous values. After reset those values are 0.
- R7: If a beat with `s_sof` high arrives while a frame is in progress, `frame_err` pulses for one cycle. The unfinished frame produces no `res_valid`, and that beat starts a fresh frame.
- R8: After reset `s_ready` is high and all result outputs are 0. `s_ready` is low in the cycle after the final beat is taken. In idle, beats without `s_sof` are accepted and discarded, and they do not move the coordinates.
- R9: The sums and the count restart at every frame start, so a result depends only on the pixels of its own frame.
- R10: Once a frame has started, `s_ready` stays high until its final beat, so a frame streams at one beat per clock with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh_i | input | 8 | Motion threshold, taken while idle |
| s_valid | input | 1 | Pixel beat valid |
| s_ready | output | 1 | Block can take a beat |
| s_sof | input | 1 | Beat is the first pixel of a frame |
| s_eol | input | 1 | Beat is the last pixel of its row |
| s_rgb | input | 24 | Current colour pixel {R,G,B} |
| s_prev_gray | input | 8 | Grey level of the same location, previous frame |
| res_valid | output | 1 | One-cycle strobe: new result on `res_x`/`res_y` |
| res_x | output | $clog2(COLS) | Centroid column |
| res_y | output | $clog2(ROWS) | Centroid row |
| res_no_motion | output | 1 | Last reported frame had no moving pixel |
| frame_err | output | 1 | One-cycle strobe: frame restarted before completion |

## Verification
Some properties are checked on every cycle: the threshold cannot change outside idle, a below-threshold pixel leaves the count unchanged, and the count restarts at a frame start. They also check that the divider remainder is smaller than the divisor, that a reported centroid lies inside the frame, that an error and a result never coincide, that a no-motion report keeps the old position, and that `s_ready` falls after the final beat. Whether the grey weights and the sums are right can only be shown by the scenarios. They compare whole frames against a model built from the requirements. This covers a moving rectangle, single pixels on either side of the threshold, a threshold change in mid-frame, a frame with no motion, a truncated frame followed by a good one, and beats sent while idle.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DIV   = 2'd3
  } mc_state_e;

  // Weighted luma, weights sum to 256 so the result fits 8 bits
  function automatic logic [7:0] rgb_to_gray(input logic [23:0] rgb);
    logic [15:0] acc;
    acc = 16'(rgb[23:16]) * 16'd77
        + 16'(rgb[15:8])  * 16'd150
        + 16'(rgb[7:0])   * 16'd29;
    return acc[15:8];
  endfunction

endpackage

// File: rtl/mc_gray_diff.sv
module mc_gray_diff #(
  parameter int X_W = 8,
  parameter int Y_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_sof,
  input  logic           in_last,
  input  logic [X_W-1:0] in_x,
  input  logic [Y_W-1:0] in_y,
  input  logic [23:0]    in_rgb,
  input  logic [7:0]     in_prev,
  output logic           o_valid,
  output logic           o_sof,
  output logic           o_last,
  output logic [X_W-1:0] o_x,
  output logic [Y_W-1:0] o_y,
  output logic [7:0]     o_diff
);
  import mc_pkg::*;

  logic [7:0] gray;
  logic [7:0] adiff;

  always_comb begin
    gray  = rgb_to_gray(in_rgb);
    adiff = (gray >= in_prev) ? (gray - in_prev) : (in_prev - gray);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_last  <= 1'b0;
      o_x     <= '0;
      o_y     <= '0;
      o_diff  <= '0;
    end else begin
      o_valid <= in_valid;
      o_sof   <= in_valid && in_sof;
      o_last  <= in_valid && in_last;
      if (in_valid) begin
        o_x    <= in_x;
        o_y    <= in_y;
        o_diff <= adiff;
      end
    end
  end

endmodule

// File: rtl/mc_accum.sv
module mc_accum #(
  parameter int X_W     = 8,
  parameter int Y_W     = 7,
  parameter int CNT_W   = 15,
  parameter int SX_W    = 23,
  parameter int SY_W    = 22,
  parameter int MAX_CNT = 19200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       thr_i,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_last,
  input  logic [X_W-1:0]   in_x,
  input  logic [Y_W-1:0]   in_y,
  input  logic [7:0]       in_diff,
  output logic [SX_W-1:0]  sum_x,
  output logic [SY_W-1:0]  sum_y,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  logic moving;
  assign moving = in_diff > thr_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_x <= '0;
      sum_y <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= in_valid && in_last;
      if (in_valid) begin
        if (in_sof) begin
          sum_x <= moving ? SX_W'(in_x) : '0;
          sum_y <= moving ? SY_W'(in_y) : '0;
          cnt   <= moving ? CNT_W'(1) : '0;
        end else if (moving) begin
          sum_x <= sum_x + SX_W'(in_x);
          sum_y <= sum_y + SY_W'(in_y);
          cnt   <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R9
  clear_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (cnt <= CNT_W'(1)));

  // R2
  below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && (in_diff <= thr_i)) |=> (cnt == $past(cnt)));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_CNT));

endmodule

// File: rtl/mc_divider.sv
module mc_divider #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 15,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int K_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] r_q;
  logic [DEN_W-1:0] d_q;
  logic [K_W-1:0]   k_q;
  logic [DEN_W:0]   r_shift;
  logic [DEN_W:0]   r_sub;
  logic             ge;

  always_comb begin
    r_shift = {r_q, q_q[NUM_W-1]};
    ge      = r_shift >= {1'b0, d_q};
    r_sub   = r_shift - {1'b0, d_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      k_q    <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      q_q    <= num_i;
      r_q    <= '0;
      d_q    <= den_i;
      k_q    <= K_W'(NUM_W);
      done_o <= 1'b0;
    end else if (k_q != '0) begin
      q_q    <= {q_q[NUM_W-2:0], ge};
      r_q    <= ge ? r_sub[DEN_W-1:0] : r_shift[DEN_W-1:0];
      k_q    <= k_q - K_W'(1);
      done_o <= (k_q == K_W'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quo_o = q_q[OUT_W-1:0];

  // R5
  rem_lt_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (r_q < d_q));

endmodule

// File: rtl/motion_centroid.sv
module motion_centroid #(
  parameter int COLS = 160,
  parameter int ROWS = 120,
  localparam int X_W = $clog2(COLS),
  localparam int Y_W = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [7:0]     thresh_i,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic           s_sof,
  input  logic           s_eol,
  input  logic [23:0]    s_rgb,
  input  logic [7:0]     s_prev_gray,
  output logic           res_valid,
  output logic [X_W-1:0] res_x,
  output logic [Y_W-1:0] res_y,
  output logic           res_no_motion,
  output logic           frame_err
);
  import mc_pkg::*;

  localparam int NPIX  = COLS * ROWS;
  localparam int CNT_W = $clog2(NPIX + 1);
  localparam int SX_W  = X_W + CNT_W;
  localparam int SY_W  = Y_W + CNT_W;

  mc_state_e        state_q;
  logic [7:0]       thr_q;
  logic [X_W-1:0]   col_q;
  logic [Y_W-1:0]   row_q;
  logic             take;
  logic             last_beat;
  logic [X_W-1:0]   px_x;
  logic [Y_W-1:0]   px_y;

  logic             d_valid, d_sof, d_last;
  logic [X_W-1:0]   d_x;
  logic [Y_W-1:0]   d_y;
  logic [7:0]       d_diff;

  logic [SX_W-1:0]  sum_x;
  logic [SY_W-1:0]  sum_y;
  logic [CNT_W-1:0] cnt;
  logic             acc_done;

  logic             div_start;
  logic             dx_done, dy_done;
  logic             got_x, got_y;
  logic [X_W-1:0]   qx;
  logic [Y_W-1:0]   qy;

  // Stream acceptance and raster coordinates
  assign s_ready   = (state_q == ST_IDLE) || (state_q == ST_RUN);
  assign take      = s_valid && s_ready && ((state_q == ST_RUN) || s_sof);
  assign px_x      = s_sof ? '0 : col_q;
  assign px_y      = s_sof ? '0 : row_q;
  assign last_beat = take && s_eol && (px_y == Y_W'(ROWS - 1));
  assign div_start = (state_q == ST_DRAIN) && acc_done && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (take) begin
      if (s_eol) begin
        col_q <= '0;
        row_q <= px_y + Y_W'(1);
      end else begin
        col_q <= (px_x == X_W'(COLS - 1)) ? px_x : px_x + X_W'(1);
        row_q <= px_y;
      end
    end
  end

  // Control sequence
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      thr_q         <= '0;
      res_valid     <= 1'b0;
      res_x         <= '0;
      res_y         <= '0;
      res_no_motion <= 1'b0;
      frame_err     <= 1'b0;
      got_x         <= 1'b0;
      got_y         <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      frame_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          thr_q <= thresh_i;
          if (take) state_q <= last_beat ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: begin
          if (take && s_sof) frame_err <= 1'b1;
          if (last_beat) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (acc_done) begin
            if (cnt == '0) begin
              res_valid     <= 1'b1;
              res_no_motion <= 1'b1;
              state_q       <= ST_IDLE;
            end else begin
              got_x   <= 1'b0;
              got_y   <= 1'b0;
              state_q <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (dx_done) begin
            got_x <= 1'b1;
            res_x <= qx;
          end
          if (dy_done) begin
            got_y <= 1'b1;
            res_y <= qy;
          end
          if ((got_x || dx_done) && (got_y || dy_done)) begin
            res_valid     <= 1'b1;
            res_no_motion <= 1'b0;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mc_gray_diff #(.X_W(X_W), .Y_W(Y_W)) diff_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (take),
    .in_sof   (s_sof),
    .in_last  (last_beat),
    .in_x     (px_x),
    .in_y     (px_y),
    .in_rgb   (s_rgb),
    .in_prev  (s_prev_gray),
    .o_valid  (d_valid),
    .o_sof    (d_sof),
    .o_last   (d_last),
    .o_x      (d_x),
    .o_y      (d_y),
    .o_diff   (d_diff)
  );

  mc_accum #(
    .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W),
    .SX_W(SX_W), .SY_W(SY_W), .MAX_CNT(NPIX)
  ) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_i    (thr_q),
    .in_valid (d_valid),
    .in_sof   (d_sof),
    .in_last  (d_last),
    .in_x     (d_x),
    .in_y     (d_y),
    .in_diff  (d_diff),
    .sum_x    (sum_x),
    .sum_y    (sum_y),
    .cnt      (cnt),
    .done     (acc_done)
  );

  mc_divider #(.NUM_W(SX_W), .DEN_W(CNT_W), .OUT_W(X_W)) div_x_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (sum_x),
    .den_i   (cnt),
    .done_o  (dx_done),
    .quo_o   (qx)
  );

  mc_divider #(.NUM_W(SY_W), .DEN_W(CNT_W), .OUT_W(Y_W)) div_y_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (sum_y),
    .den_i   (cnt),
    .done_o  (dy_done),
    .quo_o   (qy)
  );

  // R3
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(thr_q));

  // R5
  res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_x <= X_W'(COLS - 1)) && (res_y <= Y_W'(ROWS - 1))));

  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && frame_err));

  // R6
  nomo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_no_motion) |-> ($stable(res_x) && $stable(res_y)));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !s_ready);

endmodule

// File: tb/motion_centroid_tb_top.sv
`timescale 1ns/1ps
module motion_centroid_tb_top;
  localparam int COLS = 16;
  localparam int ROWS = 8;
  localparam int NPIX = COLS * ROWS;
  localparam int X_W  = $clog2(COLS);
  localparam int Y_W  = $clog2(ROWS);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     thresh_i = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic           s_sof = 1'b0;
  logic           s_eol = 1'b0;
  logic [23:0]    s_rgb = '0;
  logic [7:0]     s_prev_gray = '0;
  logic           res_valid;
  logic [X_W-1:0] res_x;
  logic [Y_W-1:0] res_y;
  logic           res_no_motion;
  logic           frame_err;

  int total = 0;
  int bad = 0;
  int stalls = 0;
  int val_cnt = 0;
  int err_cnt = 0;
  int hold_x = 0;
  int hold_y = 0;
  bit finished = 0;

  logic [23:0] cur_m  [NPIX];
  logic [7:0]  prev_m [NPIX];

  always #4 clk = ~clk;

  motion_centroid #(.COLS(COLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .thresh_i(thresh_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof), .s_eol(s_eol),
    .s_rgb(s_rgb), .s_prev_gray(s_prev_gray),
    .res_valid(res_valid), .res_x(res_x), .res_y(res_y),
    .res_no_motion(res_no_motion), .frame_err(frame_err)
  );

  always @(posedge clk) begin
    if (res_valid) val_cnt++;
    if (frame_err) err_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gray_of(input logic [23:0] c);
    return ((77 * int'(c[23:16])) + (150 * int'(c[15:8])) + (29 * int'(c[7:0]))) / 256;
  endfunction

  task automatic clear_frame();
    for (int i = 0; i < NPIX; i++) begin
      cur_m[i]  = '0;
      prev_m[i] = '0;
    end
  endtask

  task automatic set_px(input int x, input int y, input logic [23:0] c, input logic [7:0] p);
    cur_m[y*COLS + x]  = c;
    prev_m[y*COLS + x] = p;
  endtask

  task automatic push(input bit sof, input bit eol, input logic [23:0] c, input logic [7:0] p);
    @(negedge clk);
    s_valid = 1'b1; s_sof = sof; s_eol = eol; s_rgb = c; s_prev_gray = p;
    while (!s_ready) begin
      stalls++;
      @(negedge clk);
    end
  endtask

  task automatic bus_idle();
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eol = 1'b0;
  endtask

  // Sends a frame, checks streaming and the reported centroid against the model
  task automatic run_frame(input int thr, input int mid_idx, input int mid_thr, input string tag);
    int sx = 0, sy = 0, n = 0, wait_n = 0, v0, e0, d;
    v0 = val_cnt; e0 = err_cnt; stalls = 0;
    for (int i = 0; i < NPIX; i++) begin
      d = gray_of(cur_m[i]) - int'(prev_m[i]);
      if (d < 0) d = -d;
      if (d > thr) begin
        sx += i % COLS; sy += i / COLS; n++;
      end
    end
    for (int i = 0; i < NPIX; i++) begin
      if (i == mid_idx) thresh_i = 8'(mid_thr);
      push(i == 0, (i % COLS) == COLS - 1, cur_m[i], prev_m[i]);
    end
    bus_idle();
    // R8: ready low right after the final beat
    check(s_ready == 1'b0, {"R8 ", tag, " ready after last"}, int'(s_ready), 0);
    // R10: no stall inside the frame
    check(stalls == 0, {"R10 ", tag, " stalls"}, stalls, 0);
    while (val_cnt == v0 && wait_n < 500) begin
      @(negedge clk);
      wait_n++;
    end
    check(val_cnt == v0 + 1, {"R5 ", tag, " result count"}, val_cnt - v0, 1);
    if (n == 0) begin
      check(res_no_motion == 1'b1, {"R6 ", tag, " no_motion"}, int'(res_no_motion), 1);
      check(int'(res_x) == hold_x, {"R6 ", tag, " held x"}, int'(res_x), hold_x);
      check(int'(res_y) == hold_y, {"R6 ", tag, " held y"}, int'(res_y), hold_y);
    end else begin
      check(res_no_motion == 1'b0, {"R5 ", tag, " no_motion"}, int'(res_no_motion), 0);
      check(int'(res_x) == sx / n, {"R5 ", tag, " x"}, int'(res_x), sx / n);
      check(int'(res_y) == sy / n, {"R5 ", tag, " y"}, int'(res_y), sy / n);
      hold_x = sx / n; hold_y = sy / n;
    end
    check(err_cnt == e0, {"R7 ", tag, " no spurious error"}, err_cnt - e0, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(s_ready == 1'b1, "R8 reset ready", int'(s_ready), 1);
    check(res_valid == 1'b0, "R8 reset res_valid", int'(res_valid), 0);
    check(res_x == '0 && res_y == '0, "R8 reset position", int'(res_x) + int'(res_y), 0);
    check(res_no_motion == 1'b0, "R8 reset no_motion", int'(res_no_motion), 0);
    check(frame_err == 1'b0, "R8 reset frame_err", int'(frame_err), 0);
  endtask

  // R4 R5: rectangle cols 3..6 rows 2..4, x average 4.5 floors to 4
  task automatic t_block();
    clear_frame();
    for (int y = 2; y <= 4; y++)
      for (int x = 3; x <= 6; x++) set_px(x, y, 24'hFFFFFF, 8'd0);
    thresh_i = 8'd20;
    repeat (2) @(negedge clk);
    run_frame(20, -1, 20, "block");
    check(int'(res_x) == 4 && int'(res_y) == 3, "R4 block position", int'(res_x) * 10 + int'(res_y), 43);
  endtask

  // R1 R2: grey of (200,100,50) is 124; differences 31, 30 and -31 around threshold 30
  task automatic t_gray_thresh();
    clear_frame();
    set_px(10, 1, {8'd200, 8'd100, 8'd50}, 8'd93);
    set_px(2, 6,  {8'd200, 8'd100, 8'd50}, 8'd94);
    set_px(14, 7, {8'd200, 8'd100, 8'd50}, 8'd155);
    thresh_i = 8'd30;
    repeat (2) @(negedge clk);
    run_frame(30, -1, 30, "gray");
    check(int'(res_x) == 12, "R1 R2 gray x", int'(res_x), 12);
    check(int'(res_y) == 4, "R1 R2 gray y", int'(res_y), 4);
  endtask

  // R3: threshold dropped to 0 mid-frame must not count weak pixels
  task automatic t_thresh_change();
    clear_frame();
    set_px(12, 1, 24'hFFFFFF, 8'd0);
    set_px(13, 1, 24'hFFFFFF, 8'd0);
    for (int y = 4; y < ROWS; y++)
      for (int x = 0; x < COLS; x++) set_px(x, y, {8'd40, 8'd40, 8'd40}, 8'd30);
    thresh_i = 8'd30;
    repeat (2) @(negedge clk);
    run_frame(30, 5, 0, "thr_change");
    check(int'(res_x) == 12 && int'(res_y) == 1, "R3 frozen threshold", int'(res_x) * 10 + int'(res_y), 121);
    thresh_i = 8'd30;
  endtask

  // R6: nothing moves, position held from previous frame
  task automatic t_no_motion();
    clear_frame();
    for (int x = 0; x < COLS; x++) set_px(x, 3, {8'd90, 8'd90, 8'd90}, 8'd90);
    thresh_i = 8'd5;
    repeat (2) @(negedge clk);
    run_frame(5, -1, 5, "nomotion");
  endtask

  // R7: three rows then a fresh start of frame
  task automatic t_short();
    int v0, e0;
    clear_frame();
    set_px(1, 1, 24'hFFFFFF, 8'd0);
    set_px(5, 6, 24'hFFFFFF, 8'd0);
    thresh_i = 8'd20;
    repeat (2) @(negedge clk);
    v0 = val_cnt; e0 = err_cnt;
    for (int y = 0; y < 3; y++)
      for (int x = 0; x < COLS; x++)
        push(x == 0 && y == 0, x == COLS - 1, 24'hFFFFFF, 8'd0);
    push(1'b1, 1'b0, cur_m[0], prev_m[0]);
    bus_idle();
    @(negedge clk);
    check(err_cnt == e0 + 1, "R7 error pulse", err_cnt - e0, 1);
    check(val_cnt == v0, "R7 no result for short frame", val_cnt - v0, 0);
    // restart a clean complete frame (still in progress: its sof flags once more)
    repeat (2) @(negedge clk);
    e0 = err_cnt;
    for (int i = 0; i < NPIX; i++)
      push(i == 0, (i % COLS) == COLS - 1, cur_m[i], prev_m[i]);
    bus_idle();
    repeat (60) @(negedge clk);
    check(err_cnt == e0 + 1, "R7 restart flagged", err_cnt - e0, 1);
    check(val_cnt == v0 + 1, "R7 one result after restart", val_cnt - v0, 1);
    check(int'(res_x) == 3 && int'(res_y) == 3, "R7 R9 restart position", int'(res_x) * 10 + int'(res_y), 33);
    hold_x = 3; hold_y = 3;
  endtask

  // R8 R9: idle beats without sof are dropped; new frame is independent of the last
  task automatic t_idle_drop();
    stalls = 0;
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0, 24'hFFFFFF, 8'd0);
    bus_idle();
    check(stalls == 0, "R8 idle beats accepted", stalls, 0);
    clear_frame();
    set_px(9, 5, 24'hFFFFFF, 8'd0);
    thresh_i = 8'd20;
    repeat (2) @(negedge clk);
    run_frame(20, -1, 20, "idle_drop");
    check(int'(res_x) == 9 && int'(res_y) == 5, "R8 R9 single pixel", int'(res_x) * 10 + int'(res_y), 95);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_motion();
    t_block();
    t_gray_thresh();
    t_thresh_change();
    t_no_motion();
    t_short();
    t_idle_drop();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule